// File: doc/BRIEF.md
# Short-Forward Branch Predication Unit

This unit sits at the issue point of a dual-issue pipeline and looks at the two instructions issued together in one cycle. Slot 0 may hold a conditional branch, and slot 1 holds the instruction that follows it. If the branch jumps forward over exactly that one instruction, and that instruction is a plain integer ALU operation, the pair is marked as paired. Both instructions then run side by side in the two pipes.

When a paired branch resolves taken, fetch is not redirected. The unit drops the register write of the slot 1 instruction instead, which turns a short branch into predication.

Branches that do not pair take the ordinary path. A taken branch raises a redirect to its target and squashes the slot 1 write. The branch outcome arrives one cycle after issue. The redirect and write-enable outputs are valid in that resolve cycle.

Top module: `sfb_pred_unit`

## Requirements
- R1: `pair_ok_o` is high in an issue cycle only when all of the following hold: `pair_en_i` is high; slot 0 is a 32-bit conditional branch (bits [6:0] = 1100011, funct3 bits [14:12] not 010 or 011); `s1_valid_i` is high; `s1_pc_i` equals `s0_pc_i + 4`; the branch offset equals 4 plus the slot 1 length; and slot 1 belongs to the class allowed by R2 or R3. The slot 1 length is 2 bytes when `s1_insn_i[1:0]` is not 11, and 4 bytes otherwise. The branch offset is the signed value {insn[31], insn[7], insn[30:25], insn[11:8], 0}.
- R2: A 32-bit slot 1 word is allowed only when its bits [6:0] are 0110011 (reg-reg ALU), 0010011 (reg-imm ALU), 0110111 (load upper immediate) or 0010111 (add upper immediate to PC). Loads, stores, jumps and system codes are not allowed.
- R3: A 16-bit slot 1 word (bits [15:13] = f3, bits [1:0] = q) is allowed in these cases: q=00 with f3=000 and bits [12:5] non-zero; q=01 with f3 equal to 000, 010, 011 or 100; q=10 with f3=000; or q=10 with f3=100 and bits [6:2] non-zero. Move and load-immediate forms are included.
- R4: In the cycle after a paired issue, a taken outcome (`taken_i` high) gives `redirect_o` low and `s1_wb_en_o` low.
- R5: In the cycle after a paired issue, a not-taken outcome gives `redirect_o` low and `s1_wb_en_o` high.
- R6: In the cycle after an unpaired branch issue, a taken outcome gives `redirect_o` high, `redirect_pc_o` = `s0_pc_i` + offset, and `s1_wb_en_o` low. Whenever `redirect_o` is low, `redirect_pc_o` is zero.
- R7: In the cycle after an unpaired branch issue, a not-taken outcome gives no redirect, and `s1_wb_en_o` equals the issued `s1_valid_i`.
- R8: With `pair_en_i` low, `pair_ok_o` stays low and every branch follows R6/R7.
- R9: When slot 0 is not a conditional branch, the resolve cycle gives no redirect, and `s1_wb_en_o` equals the issued `s1_valid_i`. A cycle without `issue_i` gives no redirect and no write in the following cycle.
- R10: During and right after reset, `redirect_o` and `s1_wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_en_i | input | 1 | Allows pairing when high |
| issue_i | input | 1 | Slots hold an issued pair this cycle |
| s0_pc_i | input | PC_W | Slot 0 PC |
| s0_insn_i | input | 32 | Slot 0 instruction word |
| s1_valid_i | input | 1 | Slot 1 holds an instruction |
| s1_pc_i | input | PC_W | Slot 1 PC |
| s1_insn_i | input | 32 | Slot 1 word (16-bit forms in bits [15:0]) |
| taken_i | input | 1 | Branch outcome, resolve cycle |
| pair_ok_o | output | 1 | Issued pair is paired (issue cycle) |
| redirect_o | output | 1 | Fetch redirect request (resolve cycle) |
| redirect_pc_o | output | PC_W | Redirect target |
| s1_wb_en_o | output | 1 | Slot 1 register write enable (resolve cycle) |

## Verification
Every cycle, the assertions check the following:
- a paired issue never leads to a redirect, and its slot 1 write follows the inverse of the outcome;
- a redirect always comes with a squashed write;
- a cleared enable never pairs;
- a pair always has adjacent PCs;
- an idle cycle produces nothing in the next cycle.

Only the bench sweeps can show which words fall into the allowed shadow class, and whether the offset and length match is exact. These sweeps cover all 32-bit major codes and a grid of 16-bit quadrant and function codes. The bench sweeps alone also show that the redirect target arithmetic is right for forward and backward offsets.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam int         OFF_W      = 13;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_ALU32 = 2'd1,
        SH_ALU16 = 2'd2
    } shadow_kind_e;

    typedef struct packed {
        logic               is_branch;
        logic [OFF_W-1:0]   offset;
    } br_info_t;

    typedef struct packed {
        logic         valid;
        shadow_kind_e kind;
        logic [2:0]   len_bytes;
    } shadow_info_t;

    function automatic logic [2:0] insn_len(input logic [1:0] low);
        return (low == 2'b11) ? 3'd4 : 3'd2;
    endfunction

    function automatic logic c_alu_ok(input logic [15:0] c);
        logic ok;
        case ({c[1:0], c[15:13]})
            5'b00_000: ok = |c[12:5];
            5'b01_000, 5'b01_010,
            5'b01_011, 5'b01_100: ok = 1'b1;
            5'b10_000: ok = 1'b1;
            5'b10_100: ok = |c[6:2];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sfb_branch_dec.sv
module sfb_branch_dec
    import sfb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [31:0]     insn,
    input  logic [PC_W-1:0] pc,
    output br_info_t        info,
    output logic [PC_W-1:0] target
);
    localparam int EXT_W = PC_W - OFF_W;

    logic unused_regs;
    assign unused_regs = ^insn[24:15];

    always_comb begin
        info.is_branch = (insn[6:0] == OPC_BRANCH)
                       && (insn[14:12] != 3'b010)
                       && (insn[14:12] != 3'b011);
        info.offset = {insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
    end

    assign target = pc + {{EXT_W{info.offset[OFF_W-1]}}, info.offset};
endmodule

// File: rtl/sfb_shadow_class.sv
module sfb_shadow_class
    import sfb_pkg::*;
(
    input  logic [31:0]  insn,
    input  logic         valid,
    output shadow_info_t info
);
    logic unused_hi;
    assign unused_hi = ^insn[31:16];

    always_comb begin
        info.valid     = valid;
        info.len_bytes = insn_len(insn[1:0]);
        info.kind      = SH_NONE;
        if (insn[1:0] == 2'b11) begin
            case (insn[6:0])
                OPC_OP, OPC_OPIMM, OPC_LUI, OPC_AUIPC: info.kind = SH_ALU32;
                default:                               info.kind = SH_NONE;
            endcase
        end else if (c_alu_ok(insn[15:0])) begin
            info.kind = SH_ALU16;
        end
    end
endmodule

// File: rtl/sfb_resolve.sv
module sfb_resolve #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            paired,
    input  logic            is_branch,
    input  logic            s1_valid,
    input  logic [PC_W-1:0] target,
    input  logic            taken,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc,
    output logic            wb_en
);
    logic            st_valid;
    logic            st_branch;
    logic            st_paired;
    logic            st_s1;
    logic [PC_W-1:0] st_target;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid  <= 1'b0;
            st_branch <= 1'b0;
            st_paired <= 1'b0;
            st_s1     <= 1'b0;
            st_target <= '0;
        end else begin
            st_valid  <= issue;
            st_branch <= is_branch;
            st_paired <= paired;
            st_s1     <= s1_valid;
            st_target <= target;
        end
    end

    always_comb begin
        redirect    = st_valid && st_branch && !st_paired && taken;
        redirect_pc = redirect ? st_target : '0;
        wb_en       = st_valid && st_s1 && !(st_branch && taken);
    end
endmodule

// File: rtl/sfb_pred_unit.sv
module sfb_pred_unit
    import sfb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pair_en_i,
    input  logic            issue_i,
    input  logic [PC_W-1:0] s0_pc_i,
    input  logic [31:0]     s0_insn_i,
    input  logic            s1_valid_i,
    input  logic [PC_W-1:0] s1_pc_i,
    input  logic [31:0]     s1_insn_i,
    input  logic            taken_i,
    output logic            pair_ok_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic            s1_wb_en_o
);
    br_info_t        br;
    shadow_info_t    sh;
    logic [PC_W-1:0] br_target;
    logic            adjacent;
    logic            span_ok;

    sfb_branch_dec #(.PC_W(PC_W)) u_br (
        .insn   (s0_insn_i),
        .pc     (s0_pc_i),
        .info   (br),
        .target (br_target)
    );

    sfb_shadow_class u_sh (
        .insn  (s1_insn_i),
        .valid (s1_valid_i),
        .info  (sh)
    );

    always_comb begin
        adjacent  = (s1_pc_i == s0_pc_i + PC_W'(4));
        span_ok   = (br.offset == (OFF_W'(4) + OFF_W'(sh.len_bytes)));
        pair_ok_o = pair_en_i && issue_i && br.is_branch && sh.valid
                  && adjacent && span_ok && (sh.kind != SH_NONE);
    end

    sfb_resolve #(.PC_W(PC_W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue_i),
        .paired      (pair_ok_o),
        .is_branch   (br.is_branch),
        .s1_valid    (s1_valid_i),
        .target      (br_target),
        .taken       (taken_i),
        .redirect    (redirect_o),
        .redirect_pc (redirect_pc_o),
        .wb_en       (s1_wb_en_o)
    );
endmodule

// File: rtl/sfb_pred_chk.sv
module sfb_pred_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            pair_en_i,
    input logic            issue_i,
    input logic [PC_W-1:0] s0_pc_i,
    input logic            s1_valid_i,
    input logic [PC_W-1:0] s1_pc_i,
    input logic            taken_i,
    input logic            pair_ok_o,
    input logic            redirect_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic            s1_wb_en_o
);
    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        pair_ok_o |-> (issue_i && s1_valid_i && s1_pc_i == s0_pc_i + PC_W'(4))); // R1

    AST_PAIR_TAKEN_SQUASH: assert property (@(posedge clk) disable iff (rst)
        pair_ok_o |=> (!redirect_o && (taken_i ? !s1_wb_en_o : 1'b1))); // R4

    AST_PAIR_NOT_TAKEN_WRITES: assert property (@(posedge clk) disable iff (rst)
        pair_ok_o |=> (taken_i || s1_wb_en_o)); // R5

    AST_REDIRECT_SQUASH: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> !s1_wb_en_o); // R6

    AST_REDIRECT_PC_ZERO: assert property (@(posedge clk) disable iff (rst)
        !redirect_o |-> (redirect_pc_o == '0)); // R6

    AST_DISABLED_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        !pair_en_i |-> !pair_ok_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> (!redirect_o && !s1_wb_en_o)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!redirect_o && !s1_wb_en_o)); // R10
endmodule

bind sfb_pred_unit sfb_pred_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pair_en_i     (pair_en_i),
    .issue_i       (issue_i),
    .s0_pc_i       (s0_pc_i),
    .s1_valid_i    (s1_valid_i),
    .s1_pc_i       (s1_pc_i),
    .taken_i       (taken_i),
    .pair_ok_o     (pair_ok_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .s1_wb_en_o    (s1_wb_en_o)
);

// File: tb/test_sfb_pred_unit.sv
module test_sfb_pred_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pair_en_i;
    logic        issue_i;
    logic [31:0] s0_pc_i;
    logic [31:0] s0_insn_i;
    logic        s1_valid_i;
    logic [31:0] s1_pc_i;
    logic [31:0] s1_insn_i;
    logic        taken_i;
    logic        pair_ok_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic        s1_wb_en_o;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfb_pred_unit #(.PC_W(32)) i_sfb_pred_unit (
        .clk(clk), .rst(rst), .pair_en_i(pair_en_i), .issue_i(issue_i),
        .s0_pc_i(s0_pc_i), .s0_insn_i(s0_insn_i), .s1_valid_i(s1_valid_i),
        .s1_pc_i(s1_pc_i), .s1_insn_i(s1_insn_i), .taken_i(taken_i),
        .pair_ok_o(pair_ok_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .s1_wb_en_o(s1_wb_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_br(input int off, input logic [2:0] f3);
        logic [12:0] o;
        o = 13'(off);
        return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
    endfunction

    function automatic logic exp_class(input logic [31:0] w);
        logic [2:0] f3;
        if (w[1:0] == 2'b11)   // R2
            return w[6:0] == 7'b0110011 || w[6:0] == 7'b0010011 ||
                   w[6:0] == 7'b0110111 || w[6:0] == 7'b0010111;
        f3 = w[15:13];         // R3
        if (w[1:0] == 2'b00) return f3 == 3'b000 && w[12:5] != 8'd0;
        if (w[1:0] == 2'b01) return f3 == 3'b000 || f3 == 3'b010 || f3 == 3'b011 || f3 == 3'b100;
        return f3 == 3'b000 || (f3 == 3'b100 && w[6:2] != 5'd0);
    endfunction

    task automatic run_pair(input logic en, input logic [31:0] pc0, input logic [31:0] w0,
                            input logic v1, input logic [31:0] pc1, input logic [31:0] w1,
                            input logic tk, input string tag);
        logic        is_br, pair, e_redir, e_wb;
        int          off, len1;
        logic [31:0] e_pc;
        is_br = (w0[6:0] == 7'b1100011) && (w0[14:12] != 3'b010) && (w0[14:12] != 3'b011);
        off   = int'($signed({w0[31], w0[7], w0[30:25], w0[11:8], 1'b0}));
        len1  = (w1[1:0] == 2'b11) ? 4 : 2;
        pair  = en && is_br && v1 && (pc1 == pc0 + 32'd4) && (off == 4 + len1) && exp_class(w1);
        @(negedge clk);
        pair_en_i = en; issue_i = 1'b1; s0_pc_i = pc0; s0_insn_i = w0;
        s1_valid_i = v1; s1_pc_i = pc1; s1_insn_i = w1; taken_i = 1'b0;
        #1;
        chk({tag, " pair_ok R1"}, 32'(pair_ok_o), 32'(pair));
        @(negedge clk);
        issue_i = 1'b0; taken_i = tk;
        #1;
        e_redir = is_br && !pair && tk;
        e_pc    = e_redir ? pc0 + 32'(off) : 32'd0;
        e_wb    = v1 && !(is_br && tk);
        chk({tag, pair ? " redirect R4/R5" : " redirect R6/R7"}, 32'(redirect_o), 32'(e_redir));
        chk({tag, " target R6"}, redirect_pc_o, e_pc);
        chk({tag, pair ? (tk ? " wb R4" : " wb R5") : " wb R7"}, 32'(s1_wb_en_o), 32'(e_wb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] pc;
        rst = 1'b1; pair_en_i = 1'b1; issue_i = 1'b1; s0_pc_i = 0;
        s0_insn_i = enc_br(8, 3'b000); s1_valid_i = 1'b1; s1_pc_i = 4;
        s1_insn_i = 32'h00100093; taken_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("reset redirect R10", 32'(redirect_o), 0);
        chk("reset wb R10", 32'(s1_wb_en_o), 0);
        rst = 1'b0; issue_i = 1'b0;
        @(negedge clk);
        #1;
        chk("idle after reset R9", 32'({redirect_o, s1_wb_en_o}), 0);

        // R2: every 32-bit major code in the shadow slot
        for (int op = 0; op < 32; op++) begin
            for (int tk = 0; tk < 2; tk++) begin
                pc = 32'h1000 + 32'(op * 32 + tk * 16);
                run_pair(1'b1, pc, enc_br(8, 3'b001), 1'b1, pc + 4,
                         {20'h00a5b, 5'd3, 5'(op), 2'b11}, tk[0], "R2 op32");
            end
        end

        // R3: grid of 16-bit words
        for (int q = 0; q < 3; q++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int b12 = 0; b12 < 2; b12++)
                    for (int r = 0; r < 2; r++)
                        for (int d = 0; d < 2; d++)
                            for (int tk = 0; tk < 2; tk++) begin
                                logic [15:0] cw;
                                cw = {3'(f3), 1'(b12), (d != 0) ? 5'd3 : 5'd0,
                                      (r != 0) ? 5'd5 : 5'd0, 2'(q)};
                                pc = 32'h4000 + 32'((q * 8 + f3) * 64);
                                run_pair(1'b1, pc, enc_br(6, 3'b100), 1'b1, pc + 4,
                                         {16'hffff, cw}, tk[0], "R3 c16");
                            end

        // R1/R6: offset sweep with a legal 32-bit shadow op (addi)
        begin
            int offs [12] = '{-8, -4, 0, 2, 4, 6, 8, 10, 12, 16, 4094, -4096};
            foreach (offs[k])
                for (int tk = 0; tk < 2; tk++)
                    run_pair(1'b1, 32'h8000, enc_br(offs[k], 3'b101), 1'b1, 32'h8004,
                             32'h00508093, tk[0], "R1 offset");
            // 16-bit shadow with a 32-bit span is not a pair
            run_pair(1'b1, 32'h8100, enc_br(8, 3'b000), 1'b1, 32'h8104, 32'h00004505, 1'b1, "R1 span16");
        end

        // R8: enable low
        for (int tk = 0; tk < 2; tk++) begin
            run_pair(1'b0, 32'h9000, enc_br(8, 3'b000), 1'b1, 32'h9004, 32'h00508093, tk[0], "R8 off32");
            run_pair(1'b0, 32'h9100, enc_br(6, 3'b000), 1'b1, 32'h9104, 32'h0000852e, tk[0], "R8 off16");
        end

        // R1: slot 1 invalid and non-adjacent slot 1
        for (int tk = 0; tk < 2; tk++) begin
            run_pair(1'b1, 32'ha000, enc_br(8, 3'b000), 1'b0, 32'ha004, 32'h00508093, tk[0], "R1 s1inv");
            run_pair(1'b1, 32'ha100, enc_br(8, 3'b000), 1'b1, 32'ha108, 32'h00508093, tk[0], "R1 nonadj");
            run_pair(1'b1, 32'ha200, enc_br(8, 3'b010), 1'b1, 32'ha204, 32'h00508093, tk[0], "R9 badf3");
        end

        // R9: slot 0 is not a conditional branch
        for (int tk = 0; tk < 2; tk++) begin
            run_pair(1'b1, 32'hb000, 32'h002081b3, 1'b1, 32'hb004, 32'h00508093, tk[0], "R9 alu");
            run_pair(1'b1, 32'hb100, 32'h0080006f, 1'b1, 32'hb104, 32'h00508093, tk[0], "R9 jal");
            run_pair(1'b1, 32'hb200, 32'h0000c119, 1'b1, 32'hb202, 32'h00508093, tk[0], "R9 c16br");
        end

        @(negedge clk);
        #1;
        chk("idle tail R9", 32'({redirect_o, s1_wb_en_o}), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule